// File: doc/BRIEF.md
# Fan Controller Register and Interrupt Bank

This block is the software-visible side of a fan-control peripheral. A simple 32-bit bus with an address, a write enable, write data and combinational read data lets software set the PWM pulse width and the expected tach period and tolerance. The same bus reads back the fixed PWM period, the latest measured tach period and the latest temperature sample. The stored settings drive the PWM and tach blocks directly. Those blocks return a measured period, a temperature word and four one-cycle event pulses.

The events feed a four-source interrupt unit. Each event latches a pending bit. Software clears a pending bit by writing one to it. A mask bit at one keeps its source off the level-high interrupt line. A separate raw-source register shows the event inputs as they are in the current cycle. The functional logic behind the bank stays in reset until software writes one to bit 0 of the reset-release register.

Top module: `fan_regbank_top`

## Requirements
- R1: After `rst_n` is released, the following reset values hold: the mask register reads 0xFFFFFFFF, pending reads 0, `irqOut` is 0, `coreRstN` is 0, and the width, expected-period and tolerance registers and their outputs are 0.
- R2: Any write to 0x80 sets `coreRstN` from write-data bit 0 on the next cycle. A read of 0x80 returns that bit in bit 0 and zeros above it.
- R3: Addresses 0x84 (pulse width), 0x88 (expected tach period) and 0x8C (tach tolerance) are full 32-bit read/write registers. Each drives its output port `pwmWidth`, `tachExpected` or `tachTol`.
- R4: Address 0xC0 reads the PWM period parameter, and reads 1 if the parameter is 0. Writes to 0xC0 have no effect.
- R5: Address 0xC4 returns `tachMeasIn` as captured in a cycle where event bit 3 is high. Address 0xC8 returns `tempIn` as captured in a cycle where `tempValid` is high. Writes to either address have no effect.
- R6: An event pulse on `evtPulse[n]` sets pending bit n (read at 0x44) from the next cycle, whatever the mask. Bit 0 is PWM changed, bit 1 is tach error, bit 2 is temperature-requested increase and bit 3 is new measurement.
- R7: At 0x44, writing one to a bit clears that pending bit and writing zero leaves it as it was.
- R8: When an event on bit n arrives in the same cycle as a write that clears pending bit n, the bit stays set.
- R9: The mask register at 0x40 is 32-bit read/write, and a one in bits 3:0 blocks the matching source. `irqOut` is high exactly while some pending bit has its mask bit at zero.
- R10: Address 0x48 returns the live `evtPulse` value in bits 3:0 and zeros above it.
- R11: Reads of any other address return zero. Writes to other addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Byte address |
| busWe | input | 1 | Write enable, acts at the clock edge |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, same cycle |
| evtPulse | input | 4 | Event pulses: 0 PWM changed, 1 tach error, 2 temp increase, 3 new measurement |
| tachMeasIn | input | DATA_W | Measured tach period from the tach block |
| tempIn | input | DATA_W | Temperature sample |
| tempValid | input | 1 | Capture strobe for tempIn |
| coreRstN | output | 1 | Active-low reset for the functional logic |
| pwmWidth | output | DATA_W | PWM pulse width setting |
| tachExpected | output | DATA_W | Expected tach period |
| tachTol | output | DATA_W | Tach tolerance |
| irqOut | output | 1 | Level-high interrupt |

## Verification
The interrupt path is driven with single events on each source, with events on several sources at once, and with an event that coincides with its own clear. This separates per-bit latching from the order of clear and set. Mask patterns of all ones, all enabled, and one bit blocked show that the mask gates only the output line and never the pending bits. Each register is written with distinct patterns, and read-only and unmapped addresses are written with nonzero data, so that decode aliasing and stray writes show up as wrong readback.

// File: rtl/fanreg_pkg.sv
package fanreg_pkg;
  localparam int IRQ_W = 4;
  localparam int SRC_PWM_CHG = 0;
  localparam int SRC_TACH_ERR = 1;
  localparam int SRC_TEMP_INC = 2;
  localparam int SRC_NEW_MEAS = 3;

  localparam int OFF_MASK    = 'h40;
  localparam int OFF_PEND    = 'h44;
  localparam int OFF_SRC     = 'h48;
  localparam int OFF_RELEASE = 'h80;
  localparam int OFF_WIDTH   = 'h84;
  localparam int OFF_TACHPER = 'h88;
  localparam int OFF_TACHTOL = 'h8C;
  localparam int OFF_PERIOD  = 'hC0;
  localparam int OFF_MEAS    = 'hC4;
  localparam int OFF_TEMP    = 'hC8;

  typedef enum logic [3:0] {
    RD_NONE, RD_MASK, RD_PEND, RD_SRC, RD_RELEASE, RD_WIDTH,
    RD_TACHPER, RD_TACHTOL, RD_PERIOD, RD_MEAS, RD_TEMP
  } rdSel_e;

  typedef struct packed {
    logic   wrRelease;
    logic   wrWidth;
    logic   wrTachPer;
    logic   wrTachTol;
    logic   wrMask;
    logic   wrPend;
    rdSel_e rdSel;
  } strobes_t;
endpackage

// File: rtl/fanreg_ctrl.sv
module fanreg_ctrl
  import fanreg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobes_t          st
);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFF_PEND);
  localparam logic [ADDR_W-1:0] A_SRC     = ADDR_W'(OFF_SRC);
  localparam logic [ADDR_W-1:0] A_RELEASE = ADDR_W'(OFF_RELEASE);
  localparam logic [ADDR_W-1:0] A_WIDTH   = ADDR_W'(OFF_WIDTH);
  localparam logic [ADDR_W-1:0] A_TACHPER = ADDR_W'(OFF_TACHPER);
  localparam logic [ADDR_W-1:0] A_TACHTOL = ADDR_W'(OFF_TACHTOL);
  localparam logic [ADDR_W-1:0] A_PERIOD  = ADDR_W'(OFF_PERIOD);
  localparam logic [ADDR_W-1:0] A_MEAS    = ADDR_W'(OFF_MEAS);
  localparam logic [ADDR_W-1:0] A_TEMP    = ADDR_W'(OFF_TEMP);

  rdSel_e sel;

  always_comb begin
    unique case (busAddr)
      A_MASK:    sel = RD_MASK;
      A_PEND:    sel = RD_PEND;
      A_SRC:     sel = RD_SRC;
      A_RELEASE: sel = RD_RELEASE;
      A_WIDTH:   sel = RD_WIDTH;
      A_TACHPER: sel = RD_TACHPER;
      A_TACHTOL: sel = RD_TACHTOL;
      A_PERIOD:  sel = RD_PERIOD;
      A_MEAS:    sel = RD_MEAS;
      A_TEMP:    sel = RD_TEMP;
      default:   sel = RD_NONE;
    endcase
  end

  always_comb begin
    st.rdSel     = sel;
    st.wrRelease = busWe && (sel == RD_RELEASE);
    st.wrWidth   = busWe && (sel == RD_WIDTH);
    st.wrTachPer = busWe && (sel == RD_TACHPER);
    st.wrTachTol = busWe && (sel == RD_TACHTOL);
    st.wrMask    = busWe && (sel == RD_MASK);
    st.wrPend    = busWe && (sel == RD_PEND);
  end
endmodule

// File: rtl/fanreg_data.sv
module fanreg_data
  import fanreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PWM_PERIOD = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          st,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [IRQ_W-1:0]  evtPulse,
  input  logic [DATA_W-1:0] tachMeasIn,
  input  logic [DATA_W-1:0] tempIn,
  input  logic              tempValid,
  output logic              coreRstN,
  output logic [DATA_W-1:0] pwmWidth,
  output logic [DATA_W-1:0] tachExpected,
  output logic [DATA_W-1:0] tachTol,
  output logic [DATA_W-1:0] maskVec,
  output logic [IRQ_W-1:0]  pendVec,
  output logic              irqOut
);
  localparam int PERIOD_SAFE = (PWM_PERIOD == 0) ? 1 : PWM_PERIOD;
  localparam logic [DATA_W-1:0] PERIOD_VAL = DATA_W'(PERIOD_SAFE);

  logic              releaseQ;
  logic [DATA_W-1:0] widthQ, tachPerQ, tachTolQ, maskQ, measQ, tempQ;
  logic [IRQ_W-1:0]  pendQ, pendD, clrVec;

  always_comb begin
    clrVec = st.wrPend ? busWdata[IRQ_W-1:0] : '0;
    pendD  = (pendQ & ~clrVec) | evtPulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      releaseQ <= 1'b0;
      widthQ   <= '0;
      tachPerQ <= '0;
      tachTolQ <= '0;
      maskQ    <= '1;
      measQ    <= '0;
      tempQ    <= '0;
      pendQ    <= '0;
    end else begin
      if (st.wrRelease) releaseQ <= busWdata[0];
      if (st.wrWidth)   widthQ   <= busWdata;
      if (st.wrTachPer) tachPerQ <= busWdata;
      if (st.wrTachTol) tachTolQ <= busWdata;
      if (st.wrMask)    maskQ    <= busWdata;
      if (evtPulse[SRC_NEW_MEAS]) measQ <= tachMeasIn;
      if (tempValid)    tempQ    <= tempIn;
      pendQ <= pendD;
    end
  end

  always_comb begin
    unique case (st.rdSel)
      RD_MASK:    busRdata = maskQ;
      RD_PEND:    busRdata = DATA_W'(pendQ);
      RD_SRC:     busRdata = DATA_W'(evtPulse);
      RD_RELEASE: busRdata = DATA_W'(releaseQ);
      RD_WIDTH:   busRdata = widthQ;
      RD_TACHPER: busRdata = tachPerQ;
      RD_TACHTOL: busRdata = tachTolQ;
      RD_PERIOD:  busRdata = PERIOD_VAL;
      RD_MEAS:    busRdata = measQ;
      RD_TEMP:    busRdata = tempQ;
      default:    busRdata = '0;
    endcase
  end

  assign coreRstN     = releaseQ;
  assign pwmWidth     = widthQ;
  assign tachExpected = tachPerQ;
  assign tachTol      = tachTolQ;
  assign maskVec      = maskQ;
  assign pendVec      = pendQ;
  assign irqOut       = |(pendQ & ~maskQ[IRQ_W-1:0]);
endmodule

// File: rtl/fan_regbank_top.sv
module fan_regbank_top
  import fanreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int PWM_PERIOD = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [3:0]        evtPulse,
  input  logic [DATA_W-1:0] tachMeasIn,
  input  logic [DATA_W-1:0] tempIn,
  input  logic              tempValid,
  output logic              coreRstN,
  output logic [DATA_W-1:0] pwmWidth,
  output logic [DATA_W-1:0] tachExpected,
  output logic [DATA_W-1:0] tachTol,
  output logic              irqOut
);
  strobes_t          st;
  logic [DATA_W-1:0] maskVec;
  logic [IRQ_W-1:0]  pendVec;

  fanreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busAddr(busAddr), .busWe(busWe), .st(st)
  );

  fanreg_data #(.DATA_W(DATA_W), .PWM_PERIOD(PWM_PERIOD)) uData (
    .clk(clk), .rst_n(rst_n), .st(st), .busWdata(busWdata),
    .busRdata(busRdata), .evtPulse(evtPulse), .tachMeasIn(tachMeasIn),
    .tempIn(tempIn), .tempValid(tempValid), .coreRstN(coreRstN),
    .pwmWidth(pwmWidth), .tachExpected(tachExpected), .tachTol(tachTol),
    .maskVec(maskVec), .pendVec(pendVec), .irqOut(irqOut)
  );
endmodule

// File: rtl/fanreg_chk.sv
module fanreg_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWdata,
  input logic [3:0]        evtPulse,
  input logic [3:0]        pendVec,
  input logic [DATA_W-1:0] maskVec,
  input logic              coreRstN,
  input logic              irqOut
);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'('h44);
  localparam logic [ADDR_W-1:0] A_REL  = ADDR_W'('h80);

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busWe && busAddr == A_REL) |=> (coreRstN == $past(busWdata[0])));

  p_all_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVec[3:0] == 4'hF) |-> !irqOut);

  p_unmasked_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendVec & ~maskVec[3:0]) != 4'h0) |-> irqOut);

  for (genvar i = 0; i < 4; i++) begin : g_bit
    p_evt_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      evtPulse[i] |=> pendVec[i]);

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busWe && busAddr == A_PEND && busWdata[i] && !evtPulse[i]) |=> !pendVec[i]);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!evtPulse[i] && !(busWe && busAddr == A_PEND && busWdata[i]))
        |=> $stable(pendVec[i]));
  end
endmodule

bind fan_regbank_top fanreg_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
  .busWdata(busWdata), .evtPulse(evtPulse), .pendVec(pendVec),
  .maskVec(maskVec), .coreRstN(coreRstN), .irqOut(irqOut)
);

// File: tb/sim_fan_regbank_top.sv
`timescale 1ns/1ps
module sim_fan_regbank_top;
  localparam int PERIOD = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  evtPulse = '0;
  logic [31:0] tachMeasIn = '0;
  logic [31:0] tempIn = '0;
  logic        tempValid = 1'b0;
  logic        coreRstN, irqOut;
  logic [31:0] pwmWidth, tachExpected, tachTol;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fan_regbank_top #(.PWM_PERIOD(PERIOD)) u0 (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .evtPulse(evtPulse),
    .tachMeasIn(tachMeasIn), .tempIn(tempIn), .tempValid(tempValid),
    .coreRstN(coreRstN), .pwmWidth(pwmWidth), .tachExpected(tachExpected),
    .tachTol(tachTol), .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic pulse(input logic [3:0] e);
    @(negedge clk);
    evtPulse = e;
    @(negedge clk);
    evtPulse = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h40, d); check("R1 mask reset", d, 32'hFFFF_FFFF);
    rd(8'h44, d); check("R1 pending reset", d, 0);
    check("R1 irq reset", {31'b0, irqOut}, 0);
    check("R1 coreRstN reset", {31'b0, coreRstN}, 0);
    check("R1 width out reset", pwmWidth, 0);
    check("R1 tach out reset", tachExpected, 0);
    check("R1 tol out reset", tachTol, 0);
  endtask

  task automatic t_release();
    logic [31:0] d;
    wr(8'h80, 32'hFFFF_FFFE);
    check("R2 even word keeps reset", {31'b0, coreRstN}, 0);
    wr(8'h80, 32'h1);
    check("R2 released", {31'b0, coreRstN}, 1);
    rd(8'h80, d); check("R2 readback", d, 1);
    wr(8'h80, 32'h0);
    check("R2 re-held", {31'b0, coreRstN}, 0);
    wr(8'h80, 32'h1);
  endtask

  task automatic t_rw();
    logic [31:0] d;
    wr(8'h84, 32'h0000_1234);
    wr(8'h88, 32'hA5A5_0F0F);
    wr(8'h8C, 32'h8000_0001);
    rd(8'h84, d); check("R3 width readback", d, 32'h0000_1234);
    rd(8'h88, d); check("R3 tach readback", d, 32'hA5A5_0F0F);
    rd(8'h8C, d); check("R3 tol readback", d, 32'h8000_0001);
    check("R3 width port", pwmWidth, 32'h0000_1234);
    check("R3 tach port", tachExpected, 32'hA5A5_0F0F);
    check("R3 tol port", tachTol, 32'h8000_0001);
  endtask

  task automatic t_period();
    logic [31:0] d;
    rd(8'hC0, d); check("R4 period", d, PERIOD);
    wr(8'hC0, 32'h0);
    rd(8'hC0, d); check("R4 period after write", d, PERIOD);
  endtask

  task automatic t_capture();
    logic [31:0] d;
    @(negedge clk);
    tachMeasIn = 32'd777; tempIn = 32'hBEEF; tempValid = 1'b1; evtPulse = 4'b1000;
    @(negedge clk);
    tachMeasIn = 32'd999; tempIn = 32'h1111; tempValid = 1'b0; evtPulse = '0;
    rd(8'hC4, d); check("R5 measured tach", d, 32'd777);
    rd(8'hC8, d); check("R5 temperature", d, 32'hBEEF);
    wr(8'hC4, 32'h5); wr(8'hC8, 32'h6);
    rd(8'hC4, d); check("R5 tach write ignored", d, 32'd777);
    rd(8'hC8, d); check("R5 temp write ignored", d, 32'hBEEF);
    wr(8'h44, 32'hF);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    pulse(4'b0001);
    rd(8'h44, d); check("R6 pwm-changed bit0", d, 32'h1);
    pulse(4'b0110);
    rd(8'h44, d); check("R6 bits 1 and 2", d, 32'h7);
    check("R9 masked irq low", {31'b0, irqOut}, 0);
    wr(8'h44, 32'h0000_0004);
    rd(8'h44, d); check("R7 clear bit2 only", d, 32'h3);
    wr(8'h44, 32'h0);
    rd(8'h44, d); check("R7 zero write keeps", d, 32'h3);
    wr(8'h44, 32'hF);
    rd(8'h44, d); check("R7 clear all", d, 32'h0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    pulse(4'b0010);
    @(negedge clk);
    busAddr = 8'h44; busWe = 1'b1; busWdata = 32'h2; evtPulse = 4'b0010;
    @(negedge clk);
    busWe = 1'b0; busWdata = '0; evtPulse = '0;
    rd(8'h44, d); check("R8 event beats clear", d, 32'h2);
    wr(8'h44, 32'h2);
    rd(8'h44, d); check("R8 later clear works", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(8'h40, 32'hFFFF_FFF0);
    rd(8'h40, d); check("R9 mask readback", d, 32'hFFFF_FFF0);
    check("R9 no pending no irq", {31'b0, irqOut}, 0);
    pulse(4'b0001);
    check("R9 irq on unmasked", {31'b0, irqOut}, 1);
    wr(8'h40, 32'hFFFF_FFF1);
    check("R9 masked source blocked", {31'b0, irqOut}, 0);
    rd(8'h44, d); check("R9 pending kept under mask", d, 32'h1);
    pulse(4'b1000);
    check("R9 second source raises", {31'b0, irqOut}, 1);
    wr(8'h44, 32'h8);
    check("R9 irq drops after clear", {31'b0, irqOut}, 0);
    wr(8'h44, 32'hF);
  endtask

  task automatic t_source();
    logic [31:0] d;
    @(negedge clk);
    evtPulse = 4'b1010; busAddr = 8'h48;
    #1 d = busRdata;
    check("R10 live source", d, 32'hA);
    @(negedge clk);
    evtPulse = '0;
    #1 d = busRdata;
    check("R10 source idle", d, 0);
    wr(8'h44, 32'hF);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h50, d); check("R11 undefined read", d, 0);
    rd(8'h4C, d); check("R11 undefined 0x4C", d, 0);
    rd(8'h84, d); check("R11 width untouched", d, 32'h0000_1234);
    rd(8'h40, d); check("R11 mask untouched", d, 32'hFFFF_FFF1);
    rd(8'h44, d); check("R11 pending untouched", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_release();
    t_rw();
    t_period();
    t_capture();
    t_pending();
    t_race();
    t_mask();
    t_source();
    t_undef();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule